// File: doc/BRIEF.md
# Branch and Condition-Flag Control Unit

This block resolves the one-word conditional branches and the flag set/clear operations of a 16-bit processor's decode stage. Each cycle the front end may present one instruction word together with the program counter as it stands after fetch (already pointing at the next word) and the current negative, zero, overflow and carry flags. The unit classifies the word. For a branch it evaluates the condition, and when the branch is taken it produces the new program counter. For a flag operation it produces the updated flags. Any other word is flagged so that neighbouring decode logic can take it.

All results are registered. A word presented with `in_valid` high at a rising edge has its results on the outputs for exactly the following cycle. Strobes are asserted for that one cycle only. The 4-bit flag vectors are packed as {N, Z, V, C} with N in bit 3 and C in bit 0.

Top module: `bcc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every output is cleared to zero on that edge.
- R2: A word with bits 14..11 zero is a branch whose 4-bit code is {bit 15, bits 10..8}. With bit 15 clear, the codes and their take conditions are: 1 always; 2 Z=0; 3 Z=1; 4 (N xor V)=0; 5 (N xor V)=1; 6 (Z or (N xor V))=0; 7 (Z or (N xor V))=1.
- R3: With bit 15 set, the branch codes and their take conditions are: 8 N=0; 9 N=1; 10 C=0 and Z=0; 11 (C or Z)=1; 12 V=0; 13 V=1; 14 C=0; 15 C=1.
- R4: On a taken branch, `new_pc_o` equals `pc_next` plus twice the sign-extended bits 7..0, modulo 2^16. This covers offsets from -128 to +127 words.
- R5: `taken_o` is high for exactly the one cycle after a valid taken branch. In every other cycle after reset, `new_pc_o` equals the `pc_next` sampled with the word, so the program counter is left unchanged.
- R6: Branch code 0 is not a branch. This includes the byte-swap words 0x00C0 to 0x00FF. Such a word raises `unhandled_o` and never raises `taken_o`.
- R7: A word whose bits 15..5 equal 00000000101 is a flag operation (0x00A0 to 0x00BF). Bit 4 high sets, and bit 4 low clears, every flag selected by the mask in bits 3..0. Mask bit 3 selects N, bit 2 Z, bit 1 V and bit 0 C. `flags_we_o` is high for the following cycle, with the result on `flags_o`.
- R8: A flag operation with a zero mask (0x00A0 or 0x00B0) still raises `flags_we_o`, but `flags_o` equals the incoming flags unchanged.
- R9: Any valid word that is neither a branch with a nonzero code nor a flag operation raises `unhandled_o` for one cycle and raises neither `taken_o` nor `flags_we_o`. At most one of the three strobes is high in any cycle.
- R10: With `in_valid` low, no strobe is raised in the following cycle, whatever the instruction word is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 16 | Instruction word |
| pc_next | input | 16 | Program counter after fetch of this word |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| taken_o | output | 1 | One-cycle strobe: branch taken |
| new_pc_o | output | 16 | Branch target when taken, otherwise the incoming program counter |
| flags_we_o | output | 1 | One-cycle strobe: flag operation executed |
| flags_o | output | 4 | Updated flags {N,Z,V,C} |
| unhandled_o | output | 1 | One-cycle strobe: word belongs to other decode logic |

## Verification
Every result of this unit passes through a single register stage. The strobes, the target and the updated flags for a word sampled at one rising edge are therefore due right after that edge, and they are gone after the next edge. The directed tasks drive each word on a falling edge and hold it across one rising edge. They then drop `in_valid` and sample the outputs at the following falling edge, half a period after the update. A separate idle step confirms that the taken strobe has fallen one cycle later. All fifteen branch codes are swept against all sixteen flag patterns, and the offset extremes are tried with program-counter wrap.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int INSTR_W = 16;
  localparam int CODE_W  = 4;
  localparam int FLAG_W  = 4;

  typedef enum logic [1:0] {
    KIND_OTHER  = 2'd0,
    KIND_BRANCH = 2'd1,
    KIND_FLAGOP = 2'd2
  } kind_e;

  // Flag vector packing: index 3 = N, 2 = Z, 1 = V, 0 = C
  localparam int F_N = 3;
  localparam int F_Z = 2;
  localparam int F_V = 1;
  localparam int F_C = 0;
endpackage

// File: rtl/bcc_decode.sv
module bcc_decode
  import bcc_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic [INSTR_W-1:0] instr,
  output kind_e              kind,
  output logic [CODE_W-1:0]  code,
  output logic [OFF_W-1:0]   offset,
  output logic               sense,
  output logic [FLAG_W-1:0]  mask
);
  localparam logic [10:0] FLAGOP_TAG = 11'b000_0000_0101;

  logic upper_clear;
  logic is_flagop;

  always_comb begin
    code        = {instr[15], instr[10:8]};
    offset      = instr[OFF_W-1:0];
    sense       = instr[4];
    mask        = instr[FLAG_W-1:0];
    upper_clear = (instr[14:11] == 4'b0000);
    is_flagop   = (instr[15:5] == FLAGOP_TAG);
    if (upper_clear && (code != '0))
      kind = KIND_BRANCH;
    else if (is_flagop)
      kind = KIND_FLAGOP;
    else
      kind = KIND_OTHER;
  end
endmodule

// File: rtl/bcc_cond.sv
module bcc_cond
  import bcc_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic [FLAG_W-1:0] flags,
  output logic              take
);
  logic n, z, v, c, nxv;

  always_comb begin
    n   = flags[F_N];
    z   = flags[F_Z];
    v   = flags[F_V];
    c   = flags[F_C];
    nxv = n ^ v;
    unique case (code)
      4'd1:    take = 1'b1;
      4'd2:    take = ~z;
      4'd3:    take = z;
      4'd4:    take = ~nxv;
      4'd5:    take = nxv;
      4'd6:    take = ~(z | nxv);
      4'd7:    take = z | nxv;
      4'd8:    take = ~n;
      4'd9:    take = n;
      4'd10:   take = ~c & ~z;
      4'd11:   take = c | z;
      4'd12:   take = ~v;
      4'd13:   take = v;
      4'd14:   take = ~c;
      4'd15:   take = c;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcc_target.sv
module bcc_target #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  output logic [PC_W-1:0]  target
);
  localparam int EXT_W = PC_W - OFF_W - 1;

  logic [PC_W-1:0] byte_disp;

  generate
    if (EXT_W > 0) begin : g_ext
      assign byte_disp = {{EXT_W{offset[OFF_W-1]}}, offset, 1'b0};
    end else begin : g_trunc
      assign byte_disp = {offset[PC_W-2:0], 1'b0};
    end
  endgenerate

  assign target = pc + byte_disp;
endmodule

// File: rtl/bcc_flagop.sv
module bcc_flagop
  import bcc_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic              sense,
  input  logic [FLAG_W-1:0] mask,
  output logic [FLAG_W-1:0] result
);
  generate
    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
      assign result[i] = mask[i] ? sense : flags[i];
    end
  endgenerate
endmodule

// File: rtl/bcc_unit.sv
module bcc_unit
  import bcc_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [PC_W-1:0]    pc_next,
  input  logic [FLAG_W-1:0]  flags_in,
  output logic               taken_o,
  output logic [PC_W-1:0]    new_pc_o,
  output logic               flags_we_o,
  output logic [FLAG_W-1:0]  flags_o,
  output logic               unhandled_o
);
  kind_e             kind;
  logic [CODE_W-1:0] code;
  logic [OFF_W-1:0]  offset;
  logic              sense;
  logic [FLAG_W-1:0] mask;
  logic              cond_ok;
  logic [PC_W-1:0]   target;
  logic [FLAG_W-1:0] flag_res;

  bcc_decode #(.OFF_W(OFF_W)) u_dec (
    .instr(instr), .kind(kind), .code(code),
    .offset(offset), .sense(sense), .mask(mask)
  );

  bcc_cond u_cond (.code(code), .flags(flags_in), .take(cond_ok));

  bcc_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
    .pc(pc_next), .offset(offset), .target(target)
  );

  bcc_flagop u_flg (
    .flags(flags_in), .sense(sense), .mask(mask), .result(flag_res)
  );

  logic take_now, flag_now, other_now;

  always_comb begin
    take_now  = in_valid && (kind == KIND_BRANCH) && cond_ok;
    flag_now  = in_valid && (kind == KIND_FLAGOP);
    other_now = in_valid && (kind == KIND_OTHER);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_o     <= 1'b0;
      new_pc_o    <= '0;
      flags_we_o  <= 1'b0;
      flags_o     <= '0;
      unhandled_o <= 1'b0;
    end else begin
      taken_o     <= take_now;
      new_pc_o    <= take_now ? target : pc_next;
      flags_we_o  <= flag_now;
      flags_o     <= flag_now ? flag_res : flags_in;
      unhandled_o <= other_now;
    end
  end
endmodule

// File: rtl/bcc_unit_chk.sv
module bcc_unit_chk
  import bcc_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [INSTR_W-1:0] instr,
  input logic [PC_W-1:0]    pc_next,
  input logic [FLAG_W-1:0]  flags_in,
  input logic               taken_o,
  input logic [PC_W-1:0]    new_pc_o,
  input logic               flags_we_o,
  input logic [FLAG_W-1:0]  flags_o,
  input logic               unhandled_o
);
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({taken_o, flags_we_o, unhandled_o}));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !taken_o && !flags_we_o && !unhandled_o);

  p_pc_kept_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !taken_o) |-> new_pc_o == $past(pc_next));

  p_target_r4: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> new_pc_o == PC_W'($past(pc_next)
      + PC_W'(2 * $signed($past(instr[OFF_W-1:0])))));

  p_swap_word_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[15:6] == 10'b0000000011) |=> unhandled_o && !taken_o);

  p_carry_set_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[15:8] == 8'h87) |=> taken_o == $past(flags_in[F_C]));

  p_zero_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[15:5] == 11'b00000000101 && instr[3:0] == 4'h0)
      |=> flags_we_o && flags_o == $past(flags_in));
endmodule

bind bcc_unit bcc_unit_chk #(.PC_W(PC_W), .OFF_W(OFF_W)) i_bcc_unit_chk (.*);

// File: tb/test_bcc_unit.sv
`timescale 1ns/1ps
module test_bcc_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] instr;
  logic [15:0] pc_next;
  logic [3:0]  flags_in;
  logic        taken_o;
  logic [15:0] new_pc_o;
  logic        flags_we_o;
  logic [3:0]  flags_o;
  logic        unhandled_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  bcc_unit i_bcc_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .pc_next(pc_next), .flags_in(flags_in), .taken_o(taken_o),
    .new_pc_o(new_pc_o), .flags_we_o(flags_we_o), .flags_o(flags_o),
    .unhandled_o(unhandled_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit cond_of(input logic [3:0] code, input logic [3:0] f);
    logic n, z, v, c;
    {n, z, v, c} = f;
    case (code)
      4'd1:  return 1'b1;
      4'd2:  return !z;
      4'd3:  return z;
      4'd4:  return !(n ^ v);
      4'd5:  return n ^ v;
      4'd6:  return !(z | (n ^ v));
      4'd7:  return z | (n ^ v);
      4'd8:  return !n;
      4'd9:  return n;
      4'd10: return !c && !z;
      4'd11: return c | z;
      4'd12: return !v;
      4'd13: return v;
      4'd14: return !c;
      4'd15: return c;
      default: return 1'b0;
    endcase
  endfunction

  // Drive at a falling edge, capture at the rising edge, sample at the next falling edge.
  task automatic issue(input logic [15:0] w, input logic [15:0] pc, input logic [3:0] f);
    @(negedge clk);
    in_valid = 1'b1; instr = w; pc_next = pc; flags_in = f;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 taken", taken_o, 0);
    chk("R1 pc", new_pc_o, 0);
    chk("R1 we", flags_we_o, 0);
    chk("R1 flags", flags_o, 0);
    chk("R1 unh", unhandled_o, 0);
  endtask

  task automatic t_branch_sweep(input bit hi_half);
    for (int cd = 1; cd < 8; cd++) begin
      for (int f = 0; f < 16; f++) begin
        logic [3:0] code;
        bit exp;
        code = {hi_half, 3'(cd)};
        exp  = cond_of(code, 4'(f));
        issue({code[3], 4'b0000, code[2:0], 8'h05}, 16'h1000, 4'(f));
        chk(hi_half ? "R3 take" : "R2 take", taken_o, 32'(exp));
        chk(hi_half ? "R3 pc" : "R2 pc", new_pc_o, exp ? 16'h100A : 16'h1000);
      end
    end
    if (hi_half) begin
      for (int f = 0; f < 16; f++) begin
        issue(16'h8005, 16'h1000, 4'(f));
        chk("R3 plus", taken_o, 32'(!f[3]));
      end
    end
  endtask

  task automatic t_offsets();
    issue(16'h017F, 16'h2000, 4'h0);
    chk("R4 +127", new_pc_o, 16'h20FE);
    issue(16'h0180, 16'h2000, 4'h0);
    chk("R4 -128", new_pc_o, 16'h1F00);
    issue(16'h01FF, 16'h0001, 4'h0);
    chk("R4 -1 wrap", new_pc_o, 16'hFFFF);
    issue(16'h0140, 16'hFFF0, 4'h0);
    chk("R4 +64 wrap", new_pc_o, 16'h0070);
    issue(16'h0100, 16'h3456, 4'h0);
    chk("R4 zero", new_pc_o, 16'h3456);
  endtask

  task automatic t_strobe();
    issue(16'h0310, 16'h4000, 4'b0100);
    chk("R5 taken", taken_o, 1);
    chk("R5 target", new_pc_o, 16'h4020);
    @(negedge clk);
    chk("R5 one cycle", taken_o, 0);
    issue(16'h0310, 16'h4000, 4'b0000);
    chk("R5 not taken", taken_o, 0);
    chk("R5 pc kept", new_pc_o, 16'h4000);
  endtask

  task automatic t_swap();
    issue(16'h00C5, 16'h0500, 4'h0);
    chk("R6 unh", unhandled_o, 1);
    chk("R6 taken", taken_o, 0);
    chk("R6 pc", new_pc_o, 16'h0500);
    issue(16'h00FF, 16'h0500, 4'hF);
    chk("R6 unh top", unhandled_o, 1);
    chk("R6 taken top", taken_o, 0);
  endtask

  task automatic t_flagops();
    issue(16'h00BF, 16'h0, 4'h0);
    chk("R7 all set we", flags_we_o, 1);
    chk("R7 all set", flags_o, 4'hF);
    issue(16'h00AF, 16'h0, 4'hF);
    chk("R7 all clear", flags_o, 4'h0);
    issue(16'h00B1, 16'h0, 4'h0);
    chk("R7 set C", flags_o, 4'b0001);
    issue(16'h00A4, 16'h0, 4'hF);
    chk("R7 clear Z", flags_o, 4'b1011);
    issue(16'h00B9, 16'h0, 4'b0110);
    chk("R7 set N+C", flags_o, 4'b1111);
    issue(16'h00AA, 16'h0, 4'b1111);
    chk("R7 clear N+V", flags_o, 4'b0101);
    chk("R7 no branch", taken_o, 0);
  endtask

  task automatic t_nop();
    issue(16'h00A0, 16'h0, 4'b1010);
    chk("R8 we", flags_we_o, 1);
    chk("R8 clear nop", flags_o, 4'b1010);
    issue(16'h00B0, 16'h0, 4'b0101);
    chk("R8 set nop", flags_o, 4'b0101);
  endtask

  task automatic t_other();
    logic [15:0] words [4] = '{16'h0000, 16'h1234, 16'h0088, 16'h0840};
    foreach (words[i]) begin
      issue(words[i], 16'h0600, 4'hF);
      chk("R9 unh", unhandled_o, 1);
      chk("R9 taken", taken_o, 0);
      chk("R9 we", flags_we_o, 0);
    end
  endtask

  task automatic t_idle();
    @(negedge clk);
    in_valid = 1'b0; instr = 16'h0105; pc_next = 16'h0700; flags_in = 4'h0;
    @(negedge clk);
    chk("R10 taken", taken_o, 0);
    chk("R10 pc", new_pc_o, 16'h0700);
    instr = 16'h00BF;
    @(negedge clk);
    chk("R10 we", flags_we_o, 0);
    chk("R10 unh", unhandled_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; instr = '0; pc_next = '0; flags_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_branch_sweep(1'b0);
    t_branch_sweep(1'b1);
    t_offsets();
    t_strobe();
    t_swap();
    t_flagops();
    t_nop();
    t_other();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule